// File: doc/BRIEF.md
# Self-Routing Butterfly Switch Network

This block connects N input lines to N output lines through log2 N ranks of 2x2 switch elements, N/2 switches per rank. A packet offered on input line A carries a destination index B and a data word. No routing table exists. Each rank looks at one bit of the relative address A XOR B and decides from that bit alone. A 0 keeps the packet on its own line (straight). A 1 moves it to the partner line (cross). The partner of line j at rank s is line j with bit s inverted. Because every rank fixes exactly one bit of the line index, each source and destination pair has one path, and that path always passes through all log2 N ranks.

Every rank ends in a register on each line. A packet that meets no contention therefore comes out log2 N cycles after it is accepted. Two packets at one switch may both want the same output. A per-switch round-robin bit then picks one, and the other stays where it is and retries on the next cycle. At the first rank it stays at the sender, which sees its ready signal low. At later ranks it stays in the previous rank's register. A waiting register blocks only its own line. The output side has no back-pressure: a packet in the last rank is presented for exactly one cycle.

Top module: `butterfly_router`

## Requirements
- R1: After reset every out_valid bit is 0, and no packet appears until one has been accepted at an input.
- R2: At rank s (s = 0 is the first rank) a packet goes straight when bit s of source XOR destination is 0 and crosses when it is 1. After rank s, the line index matches the destination in bits 0..s and the source in the higher bits. As a result, every permutation of the form dst = src XOR k is delivered with no contention.
- R3: A packet accepted on input line A with destination B appears once only, on out_valid[B]. It carries out_src = A and its data word unchanged. Field i of a flat bus occupies bits [i*W +: W].
- R4: A packet that meets no contention appears on its output exactly LG cycles after the clock edge that accepts it. For example, the identity permutation sends all N packets in the same cycle and all arrive LG cycles later.
- R5: When both inputs of a switch want the same output, exactly one is forwarded. The other stays put with its contents unchanged and is forwarded in a later cycle. No packet is lost.
- R6: Each switch has a round-robin bit that starts out favouring its lower-numbered line. After each contended grant, the side that lost is favoured at that switch's next contention.
- R7: in_ready[i] is 1 in exactly those cycles in which a valid packet on input i is taken. A packet offered while in_ready[i] is 0 is not taken, and the sender must keep offering it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N | A packet is offered on input line i |
| in_dst | input | N*LG | Destination index for each input line |
| in_data | input | N*DW | Data word for each input line |
| in_ready | output | N | The offered packet on line i is taken at this edge |
| out_valid | output | N | A packet leaves on output line j |
| out_src | output | N*LG | Source index of the packet on output line j |
| out_data | output | N*DW | Data word of the packet on output line j |

## Verification
The bench builds the network with LG = 3 and DW = 8, which gives eight lines and three ranks. With these values the bench can drive all seven non-trivial XOR permutations and the identity pattern at full rate. It can also force contention separately at the first and the middle rank, so both the wait at the sender and the wait inside a rank register are exercised, together with the round-robin reversal at one switch. Random traffic then checks every delivery against a scoreboard keyed by the data word, which serves as a unique tag.

// File: rtl/butterfly_router.sv
module butterfly_router #(
  parameter int LG = 3,
  parameter int DW = 8,
  localparam int N = 1 << LG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     in_valid,
  input  logic [N*LG-1:0]  in_dst,
  input  logic [N*DW-1:0]  in_data,
  output logic [N-1:0]     in_ready,
  output logic [N-1:0]     out_valid,
  output logic [N*LG-1:0]  out_src,
  output logic [N*DW-1:0]  out_data
);

  logic          rv   [LG][N];
  logic [LG-1:0] rd   [LG][N];
  logic [LG-1:0] rs   [LG][N];
  logic [DW-1:0] rx   [LG][N];
  logic          prio [LG][N];

  logic          cv   [LG][N];
  logic [LG-1:0] cd   [LG][N];
  logic [LG-1:0] cs   [LG][N];
  logic [DW-1:0] cx   [LG][N];
  logic          mv   [LG+1][N];
  logic          ld   [LG][N];
  logic          selp [LG][N];
  logic          flip [LG][N];

  always_comb begin
    for (int s = 0; s < LG; s++) begin
      for (int m = 0; m < N; m++) begin
        if (s == 0) begin
          cv[s][m] = in_valid[m];
          cd[s][m] = in_dst[m*LG +: LG];
          cs[s][m] = LG'(m);
          cx[s][m] = in_data[m*DW +: DW];
        end else begin
          cv[s][m] = rv[s-1][m];
          cd[s][m] = rd[s-1][m];
          cs[s][m] = rs[s-1][m];
          cx[s][m] = rx[s-1][m];
        end
        mv[s][m]   = 1'b0;
        ld[s][m]   = 1'b0;
        selp[s][m] = 1'b0;
        flip[s][m] = 1'b0;
      end
    end
    for (int m = 0; m < N; m++) mv[LG][m] = 1'b1;
    for (int s = LG - 1; s >= 0; s--) begin
      for (int j = 0; j < N; j++) begin
        int   p, lo;
        logic jb, ro, rp, ownwin, acc;
        p      = j ^ (1 << s);
        lo     = j & ~(1 << s);
        jb     = 1'((j >> s) & 1);
        ro     = cv[s][j] && (cd[s][j][s] == jb);
        rp     = cv[s][p] && (cd[s][p][s] == jb);
        ownwin = ro && (!rp || (prio[s][lo] ? (j != lo) : (j == lo)));
        acc    = !rv[s][j] || mv[s+1][j];
        ld[s][j]   = acc && (ro || rp);
        selp[s][j] = !ownwin;
        if (ld[s][j]) begin
          if (ownwin) mv[s][j] = 1'b1;
          else        mv[s][p] = 1'b1;
        end
        if (ld[s][j] && ro && rp) flip[s][lo] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < LG; s++) begin
        for (int j = 0; j < N; j++) begin
          rv[s][j]   <= 1'b0;
          rd[s][j]   <= '0;
          rs[s][j]   <= '0;
          rx[s][j]   <= '0;
          prio[s][j] <= 1'b0;
        end
      end
    end else begin
      for (int s = 0; s < LG; s++) begin
        for (int j = 0; j < N; j++) begin
          if (ld[s][j]) begin
            rv[s][j] <= 1'b1;
            rd[s][j] <= selp[s][j] ? cd[s][j ^ (1 << s)] : cd[s][j];
            rs[s][j] <= selp[s][j] ? cs[s][j ^ (1 << s)] : cs[s][j];
            rx[s][j] <= selp[s][j] ? cx[s][j ^ (1 << s)] : cx[s][j];
          end else if (mv[s+1][j]) begin
            rv[s][j] <= 1'b0;
          end
          if (flip[s][j]) prio[s][j] <= !prio[s][j];
        end
      end
    end
  end

  for (genvar gm = 0; gm < N; gm++) begin : g_port
    assign in_ready[gm]              = mv[0][gm];
    assign out_valid[gm]             = rv[LG-1][gm];
    assign out_src[gm*LG +: LG]      = rs[LG-1][gm];
    assign out_data[gm*DW +: DW]     = rx[LG-1][gm];
  end

  for (genvar gs = 0; gs < LG; gs++) begin : g_chk
    for (genvar gj = 0; gj < N; gj++) begin : g_line
      localparam logic [LG-1:0] LINE = LG'(gj);
      localparam logic [LG-1:0] LOW  = LG'((2 << gs) - 1);
      p_stage_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rv[gs][gj] |-> (((rd[gs][gj] & LOW) | (rs[gs][gj] & ~LOW)) == LINE));
      if (gs < LG - 1) begin : g_hold
        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
          (rv[gs][gj] && !mv[gs+1][gj]) |=>
            (rv[gs][gj] && $stable(rd[gs][gj]) && $stable(rs[gs][gj]) && $stable(rx[gs][gj])));
      end
    end
  end

  for (genvar gk = 0; gk < N / 2; gk++) begin : g_sw0
    localparam int LO = 2 * gk;
    localparam int HI = 2 * gk + 1;
    logic conf;
    assign conf = in_valid[LO] && in_valid[HI] && (in_dst[LO*LG] == in_dst[HI*LG]);
    p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
      conf |-> !(in_ready[LO] && in_ready[HI]));
    p_rr_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (conf && in_ready[LO]) |=> !(conf && in_ready[LO]));
    p_rr_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (conf && in_ready[HI]) |=> !(conf && in_ready[HI]));
  end

endmodule

// File: tb/butterfly_router_bench.sv
module butterfly_router_bench;
  localparam int LG = 3;
  localparam int DW = 8;
  localparam int N  = 1 << LG;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    in_valid = '0;
  logic [N*LG-1:0] in_dst = '0;
  logic [N*DW-1:0] in_data = '0;
  logic [N-1:0]    in_ready, out_valid;
  logic [N*LG-1:0] out_src;
  logic [N*DW-1:0] out_data;

  butterfly_router #(.LG(LG), .DW(DW)) u_butterfly_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_src(out_src), .out_data(out_data));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    t_src[256], t_dst[256], t_start[256], t_exp[256], t_acc[256];
  bit    t_used[256], t_done[256];
  string t_req[256];
  int    q[N][$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add(int tag, int src, int dst, int start, int expo, string req);
    t_used[tag] = 1; t_done[tag] = 0; t_src[tag] = src; t_dst[tag] = dst;
    t_start[tag] = start; t_exp[tag] = expo; t_acc[tag] = -1; t_req[tag] = req;
    q[src].push_back(tag);
  endtask

  function automatic bit all_done();
    for (int t = 0; t < 256; t++) if (t_used[t] && !t_done[t]) return 0;
    return 1;
  endfunction

  task automatic drain();
    int w = 0;
    while (!all_done() && w < 3000) begin @(negedge clk); w++; end
    chk(all_done(), "R5", "packets still in flight", 0, 1);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      for (int j = 0; j < N; j++) begin
        if (out_valid[j] === 1'b1) begin
          int tag;
          tag = int'(out_data[j*DW +: DW]);
          chk(t_used[tag] && t_acc[tag] >= 0 && !t_done[tag], "R3", "unexpected packet tag", tag, -1);
          if (t_used[tag]) begin
            t_done[tag] = 1;
            chk(j == t_dst[tag], "R3", "output line", j, t_dst[tag]);
            chk(int'(out_src[j*LG +: LG]) == t_src[tag], "R3", "source field", int'(out_src[j*LG +: LG]), t_src[tag]);
            if (t_exp[tag] >= 0) chk(cyc == t_exp[tag], t_req[tag], "arrival cycle", cyc, t_exp[tag]);
          end
        end
      end
      in_valid = '0;
      for (int i = 0; i < N; i++) begin
        if (q[i].size() > 0 && t_start[q[i][0]] <= cyc) begin
          in_valid[i] = 1'b1;
          in_dst[i*LG +: LG] = LG'(t_dst[q[i][0]]);
          in_data[i*DW +: DW] = DW'(q[i][0]);
        end
      end
      #2;
      for (int i = 0; i < N; i++) begin
        if (in_valid[i] && in_ready[i]) begin
          t_acc[q[i][0]] = cyc;
          void'(q[i].pop_front());
        end
      end
    end
  end

  initial begin
    wait (cyc >= 20000);
    chk(0, "WATCHDOG", "run did not finish", cyc, 20000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    chk(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
    repeat (3) @(negedge clk); #3;
    chk(out_valid == '0, "R1", "out_valid idle", int'(out_valid), 0);

    // R6: lines 0 and 1 both to output 0, lower line wins first, then reversed
    @(negedge clk); s = cyc + 2;
    add(1, 0, 0, s, s + LG, "R6");
    add(2, 1, 0, s, s + LG + 1, "R6");
    drain();
    @(negedge clk); s = cyc + 2;
    add(3, 0, 0, s, s + LG + 1, "R6");
    add(4, 1, 0, s, s + LG, "R6");
    drain();

    // R5 / R7: contention in the middle rank, loser held, line 2 blocked
    @(negedge clk); s = cyc + 2;
    add(5, 0, 0, s, s + LG, "R5");
    add(6, 2, 0, s, s + LG + 1, "R5");
    add(7, 2, 2, s + 1, s + LG + 2, "R7");
    while (cyc < s + 1) @(negedge clk);
    #3;
    chk(in_valid[2] && !in_ready[2], "R7", "in_ready while line blocked", int'(in_ready[2]), 0);
    drain();

    // R4: identity permutation
    @(negedge clk); s = cyc + 2;
    for (int i = 0; i < N; i++) add(16 + i, i, i, s, s + LG, "R4");
    drain();

    // R2: every XOR permutation, back to back
    @(negedge clk); s = cyc + 2;
    for (int x = 1; x < N; x++)
      for (int i = 0; i < N; i++) add(32 + 8 * x + i, i, i ^ x, s + x, s + x + LG, "R2");
    drain();

    // R3 / R5: random traffic, no timing expectation
    @(negedge clk); s = cyc + 2;
    for (int k = 0; k < 100; k++)
      add(100 + k, int'($urandom % N), int'($urandom % N), s + int'($urandom % 40), -1, "R3");
    drain();

    for (int t = 0; t < 256; t++)
      if (t_used[t]) chk(t_done[t], "R5", "packet delivered", int'(t_done[t]), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule